// File: doc/BRIEF.md
# DDR Command Timing Checker

This block watches the command pins of a DDR SDRAM device, one sample per command clock, and reports any command that arrives too early for the device's timing rules. It never drives the bus. For each of four banks it keeps whether a row is open, how many cycles have passed since that bank was last activated, precharged and written, and how long an automatic precharge still keeps the bank busy. Two device-wide counters cover activate-to-activate and write-to-read spacing.

Every limit is a parameter counted in clock cycles. A limit given in nanoseconds is turned into cycles by rounding up. The defaults suit a 5 ns clock: tRCD 3, tRP 3, tRAS 8, tRC 11, tRRD 2, tWR 3 and tWTR 1. When a command breaks a rule, the block raises a one-cycle flag and a 4-bit code that names the rule. This lets a simulation environment, or logic on silicon, catch scheduling bugs in a memory controller. A read or write with auto-precharge may be issued as soon as tRCD allows. The implied precharge is then delayed until tRAS has elapsed, and the bank stays busy until that delayed close plus tRP.

Top module: `ddr_cmd_timing_chk`

## Requirements
- R1: A command is decoded only when cs_n is low and cke was high at both the current and the previous sampled edge. Otherwise the cycle is ignored, with no violation and no change of state. {ras_n,cas_n,we_n} decodes as: 000 mode register set, 010 precharge, 011 activate, 100 write, 101 read; all other values are ignored.
- R2: A violation raises viol for exactly the one cycle after the edge that sampled the offending command, together with viol_code. When viol is low, viol_code is 0. When several rules fail at once, the smallest code is reported. A violating command still updates the tracked state.
- R3: A read or write to an open bank fewer than T_RCD cycles after its activate reports code 1.
- R4: A read or write to a bank with no open row reports code 8.
- R5: Code 2 is reported in three cases: an activate to a bank that is still open; an activate fewer than T_RP cycles after that bank's precharge; a mode register set fewer than T_RP cycles after any bank's precharge.
- R6: A precharge of an open bank fewer than T_RAS cycles after its activate reports code 3.
- R7: An activate fewer than T_RC cycles after the same bank's activate reports code 4. An activate fewer than T_RRD cycles after any activate reports code 5.
- R8: A precharge of an open bank fewer than 1 + BL/2 + T_WR cycles after a write to that bank reports code 6.
- R9: A read fewer than 1 + BL/2 + T_WTR cycles after any write reports code 7.
- R10: A read or write with auto-precharge (a10 high) closes the bank. The bank then stays busy until cycle n + max(BL/2, T_RAS − (n − activate)) + T_RP after a read, or n + max(BL/2 + 1 + T_WR, T_RAS − (n − activate)) + T_RP after a write. Any command to a busy bank reports code 2 after an auto-precharge read and code 6 after an auto-precharge write.
- R11: A precharge with a10 high applies to every bank and ignores ba. With a10 low it applies only to bank ba.
- R12: A mode register set while any bank is open reports code 9. A mode register set with ba = 0 sets the burst length from addr_lo: 001 gives 2, 010 gives 4, 011 gives 8. Other addr_lo values leave the burst length unchanged. After reset the burst length is 4.
- R13: An asserted rst_n clears viol and viol_code at once, closes all banks and saturates every spacing counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| ba | input | 2 | Bank address |
| addr_lo | input | 3 | Low address bits, burst length field of a mode register set |
| viol | output | 1 | One-cycle violation flag |
| viol_code | output | 4 | Code of the broken rule, 0 when none |

## Verification
The embedded properties check, on every cycle, that viol_code is zero whenever viol is low and stays within 1..9 whenever viol is high. They also check that a cycle with no decoded command is never followed by a flag, and that an auto-precharge leaves its bank closed and busy. Only the bench's scenarios can show that each spacing rule fires at the exact cycle count and not one cycle later. The same holds for the tRAS lockout stretching the busy window, for the smallest code winning when several rules fail, for an all-bank precharge resetting every bank, and for burst length changes moving the write-recovery and write-to-read windows.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_MRS
  } cmd_e;

  localparam int NCODE  = 10;
  localparam int CODEW  = 4;

  localparam int C_RCD  = 1;
  localparam int C_RP   = 2;
  localparam int C_RAS  = 3;
  localparam int C_RC   = 4;
  localparam int C_RRD  = 5;
  localparam int C_WR   = 6;
  localparam int C_WTR  = 7;
  localparam int C_IDLE = 8;
  localparam int C_MRS  = 9;

endpackage

// File: rtl/ddrchk_decode.sv
module ddrchk_decode
  import ddrchk_pkg::*;
(
  input  logic cke,
  input  logic cke_q,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (cke && cke_q && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        default: cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ddrchk_bank.sv
module ddrchk_bank
  import ddrchk_pkg::*;
#(
  parameter int CW    = 8,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 8,
  parameter int T_RC  = 11,
  parameter int T_WR  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             a10,
  input  logic [CW-1:0]    bl_half,
  output logic [NCODE-1:0] err_o
);

  localparam logic [CW-1:0] K_ONE = CW'(1);
  localparam logic [CW-1:0] K_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] K_RP  = CW'(T_RP);
  localparam logic [CW-1:0] K_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] K_RC  = CW'(T_RC);
  localparam logic [CW-1:0] K_WR  = CW'(T_WR);

  logic          open_q, open_d, lockw_q, lockw_d, locked;
  logic [CW-1:0] act_q, act_d, pre_q, pre_d, wr_q, wr_d, lock_q, lock_d;
  logic [CW-1:0] ras_rem, base, close_dly, wrec;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (&v) ? v : v + K_ONE;
  endfunction

  // rule evaluation for a command aimed at this bank
  always_comb begin
    err_o  = '0;
    locked = (lock_q != '0);
    wrec   = K_ONE + bl_half + K_WR;
    if (sel) begin
      case (cmd)
        CMD_ACT: begin
          if (locked) err_o[lockw_q ? C_WR : C_RP] = 1'b1;
          if (open_q || pre_q < K_RP) err_o[C_RP] = 1'b1;
          if (act_q < K_RC) err_o[C_RC] = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (locked) err_o[lockw_q ? C_WR : C_RP] = 1'b1;
          if (!open_q) err_o[C_IDLE] = 1'b1;
          if (open_q && act_q < K_RCD) err_o[C_RCD] = 1'b1;
        end
        CMD_PRE: begin
          if (locked) err_o[lockw_q ? C_WR : C_RP] = 1'b1;
          if (open_q && act_q < K_RAS) err_o[C_RAS] = 1'b1;
          if (open_q && wr_q < wrec) err_o[C_WR] = 1'b1;
        end
        CMD_MRS: begin
          if (open_q) err_o[C_MRS] = 1'b1;
          if (locked || pre_q < K_RP) err_o[C_RP] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // next state
  always_comb begin
    act_d     = sat_inc(act_q);
    pre_d     = sat_inc(pre_q);
    wr_d      = sat_inc(wr_q);
    open_d    = open_q;
    lockw_d   = lockw_q;
    lock_d    = (lock_q != '0) ? lock_q - K_ONE : lock_q;
    ras_rem   = (act_q < K_RAS) ? K_RAS - act_q : '0;
    base      = (cmd == CMD_WR) ? bl_half + K_ONE + K_WR : bl_half;
    close_dly = ((base > ras_rem) ? base : ras_rem) + K_RP - K_ONE;
    if (sel) begin
      case (cmd)
        CMD_ACT: begin
          act_d  = K_ONE;
          open_d = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (cmd == CMD_WR) wr_d = K_ONE;
          if (a10) begin
            open_d  = 1'b0;
            lock_d  = close_dly;
            lockw_d = (cmd == CMD_WR);
          end
        end
        CMD_PRE: begin
          pre_d  = K_ONE;
          open_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      lockw_q <= 1'b0;
      act_q   <= '1;
      pre_q   <= '1;
      wr_q    <= '1;
      lock_q  <= '0;
    end else begin
      open_q  <= open_d;
      lockw_q <= lockw_d;
      act_q   <= act_d;
      pre_q   <= pre_d;
      wr_q    <= wr_d;
      lock_q  <= lock_d;
    end
  end

  // R10: an auto-precharge closes the bank and leaves it busy
  p_ap_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (cmd == CMD_RD || cmd == CMD_WR) && a10) |=> (!open_q && lock_q != '0));

  // R5: an activate always leaves the bank open
  p_act_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cmd == CMD_ACT) |=> open_q);

endmodule

// File: rtl/ddr_cmd_timing_chk.sv
module ddr_cmd_timing_chk
  import ddrchk_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int CW    = 8,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 8,
  parameter int T_RC  = 11,
  parameter int T_RRD = 2,
  parameter int T_WR  = 3,
  parameter int T_WTR = 1,
  localparam int BAW  = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             a10,
  input  logic [BAW-1:0]   ba,
  input  logic [2:0]       addr_lo,
  output logic             viol,
  output logic [CODEW-1:0] viol_code
);

  localparam logic [CW-1:0] K_ONE = CW'(1);
  localparam logic [CW-1:0] K_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] K_WTR = CW'(T_WTR);

  logic             rs_meta, rst_n_s;
  logic             cke_q;
  cmd_e             cmd;
  logic [CW-1:0]    bl_half_q, bl_half_d;
  logic [CW-1:0]    any_act_q, any_act_d, any_wr_q, any_wr_d;
  logic [NBANK-1:0] sel;
  logic [NCODE-1:0] bank_err [NBANK];
  logic [NCODE-1:0] all_err;
  logic             viol_d;
  logic [CODEW-1:0] code_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_n_s <= rs_meta;
    end
  end

  ddrchk_decode u_dec (
    .cke   (cke),
    .cke_q (cke_q),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign sel[i] = (cmd == CMD_MRS) || (cmd == CMD_PRE && a10) ||
                    (ba == BAW'(i));
    ddrchk_bank #(
      .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
      .T_RC(T_RC), .T_WR(T_WR)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .cmd     (cmd),
      .sel     (sel[i]),
      .a10     (a10),
      .bl_half (bl_half_q),
      .err_o   (bank_err[i])
    );
  end

  // device-wide rules, burst length and code priority
  always_comb begin
    all_err = '0;
    for (int i = 0; i < NBANK; i++) all_err = all_err | bank_err[i];
    if (cmd == CMD_ACT && any_act_q < K_RRD) all_err[C_RRD] = 1'b1;
    if (cmd == CMD_RD && any_wr_q < K_ONE + bl_half_q + K_WTR) all_err[C_WTR] = 1'b1;

    viol_d = |all_err;
    code_d = '0;
    for (int c = NCODE - 1; c >= 1; c--) if (all_err[c]) code_d = CODEW'(c);

    any_act_d = (&any_act_q) ? any_act_q : any_act_q + K_ONE;
    any_wr_d  = (&any_wr_q) ? any_wr_q : any_wr_q + K_ONE;
    if (cmd == CMD_ACT) any_act_d = K_ONE;
    if (cmd == CMD_WR)  any_wr_d  = K_ONE;

    bl_half_d = bl_half_q;
    if (cmd == CMD_MRS && ba == '0) begin
      case (addr_lo)
        3'd1:    bl_half_d = CW'(1);
        3'd2:    bl_half_d = CW'(2);
        3'd3:    bl_half_d = CW'(4);
        default: bl_half_d = bl_half_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cke_q     <= 1'b0;
      bl_half_q <= CW'(2);
      any_act_q <= '1;
      any_wr_q  <= '1;
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      cke_q     <= cke;
      bl_half_q <= bl_half_d;
      any_act_q <= any_act_d;
      any_wr_q  <= any_wr_d;
      viol      <= viol_d;
      viol_code <= code_d;
    end
  end

  // R2: code is zero whenever no violation is flagged
  p_code_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !viol |-> (viol_code == '0));

  // R2: a flagged code names a defined rule
  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    viol |-> (viol_code >= CODEW'(1) && viol_code <= CODEW'(NCODE - 1)));

  // R1: a cycle with no decoded command never produces a flag
  p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == CMD_NONE) |=> !viol);

endmodule

// File: tb/sim_ddr_cmd_timing_chk.sv
module sim_ddr_cmd_timing_chk;

  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101,
                         WR = 3'b100, PR = 3'b010, MR = 3'b000;

  logic       clk = 1'b0;
  logic       rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [2:0] addr_lo;
  logic       viol;
  logic [3:0] viol_code;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  ddr_cmd_timing_chk u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba), .addr_lo(addr_lo),
    .viol(viol), .viol_code(viol_code)
  );

  // {cs_n, rcw[2:0], ba[1:0], a10, addr_lo[2:0], exp_viol, exp_code[3:0]}
  function automatic logic [14:0] mk(input logic cs, input logic [2:0] c,
                                     input int b, input logic a,
                                     input int al, input int code);
    return {cs, c, 2'(b), a, 3'(al), (code != 0), 4'(code)};
  endfunction

  function automatic string req_of(input int code);
    case (code)
      1: return "R3";  2: return "R5";  3: return "R6";
      4: return "R7";  5: return "R7";  6: return "R8";
      7: return "R9";  8: return "R4";  9: return "R12";
      default: return "R2";
    endcase
  endfunction

  localparam int NV = 45;
  localparam logic [14:0] TBL [NV] = '{
    mk(0,MR,0,0,2,0),   // 0  BL4, all idle
    mk(1,RD,0,0,0,0),   // 1  deselected, R1
    mk(0,ACT,0,0,0,0),  // 2
    mk(0,ACT,1,0,0,5),  // 3  tRRD
    mk(0,RD,0,0,0,1),   // 4  tRCD
    mk(0,RD,0,0,0,0),   // 5  tRCD met, pulse dropped
    mk(0,PR,0,0,0,3),   // 6  tRAS
    mk(0,ACT,0,0,0,2),  // 7  tRP and tRC, smaller code wins
    mk(0,RD,2,0,0,8),   // 8  idle bank
    mk(0,WR,1,0,0,0),   // 9
    mk(0,RD,1,0,0,7),   // 10 tWTR
    mk(1,NOP,0,0,0,0),  // 11
    mk(1,NOP,0,0,0,0),  // 12
    mk(0,RD,1,0,0,0),   // 13 1+BL/2+tWTR met
    mk(0,PR,1,0,0,6),   // 14 write recovery
    mk(0,MR,0,0,0,2),   // 15 tRP and open bank
    mk(0,PR,0,1,0,0),   // 16 precharge all, R11
    mk(0,MR,0,0,0,2),   // 17 tRP after precharge all, R11
    mk(1,NOP,0,0,0,0),  // 18
    mk(0,MR,0,0,3,0),   // 19 BL8, R12
    mk(0,ACT,2,0,0,0),  // 20
    mk(1,NOP,0,0,0,0),  // 21
    mk(1,NOP,0,0,0,0),  // 22
    mk(0,RD,2,1,0,0),   // 23 read auto-precharge at tRCD, R10
    mk(0,ACT,3,0,0,0),  // 24
    mk(1,NOP,0,0,0,0),  // 25
    mk(1,NOP,0,0,0,0),  // 26
    mk(1,NOP,0,0,0,0),  // 27
    mk(1,NOP,0,0,0,0),  // 28
    mk(1,NOP,0,0,0,0),  // 29
    mk(0,RD,2,0,0,2),   // 30 bank busy by tRAS lockout, R10
    mk(0,ACT,2,0,0,0),  // 31 busy window over, R10
    mk(1,NOP,0,0,0,0),  // 32
    mk(0,WR,3,1,0,0),   // 33 write auto-precharge, R10
    mk(1,NOP,0,0,0,0),  // 34
    mk(1,NOP,0,0,0,0),  // 35
    mk(1,NOP,0,0,0,0),  // 36
    mk(1,NOP,0,0,0,0),  // 37
    mk(1,NOP,0,0,0,0),  // 38
    mk(1,NOP,0,0,0,0),  // 39
    mk(1,NOP,0,0,0,0),  // 40
    mk(1,NOP,0,0,0,0),  // 41
    mk(1,NOP,0,0,0,0),  // 42
    mk(0,ACT,3,0,0,6),  // 43 one cycle early after write AP, R10
    mk(1,NOP,0,0,0,0)   // 44
  };

  task automatic check(input string req, input logic ev, input logic [3:0] ec);
    n_chk++;
    if (viol !== ev || viol_code !== ec) begin
      n_err++;
      $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
               req, viol, viol_code, ev, ec);
    end
  endtask

  task automatic drive(input logic cs, input logic [2:0] c, input logic [1:0] b,
                       input logic a, input logic [2:0] al);
    cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; a10 = a; addr_lo = al;
  endtask

  task automatic step(input logic cs, input logic [2:0] c, input logic [1:0] b,
                      input logic a, input logic [2:0] al);
    @(negedge clk);
    drive(cs, c, b, a, al);
    @(posedge clk);
    #1;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2: watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b0;
    drive(1'b1, NOP, 2'd0, 1'b0, 3'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; cke = 1'b1;
    repeat (4) step(1'b1, NOP, 2'd0, 1'b0, 3'd0);
    check("R13", 1'b0, 4'd0);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] e;
      e = TBL[i];
      step(e[14], e[13:11], e[10:9], e[8], e[7:5]);
      check(req_of(int'(e[3:0])), e[4], e[3:0]);
    end

    // R1: clock enable low at the previous edge masks the command
    @(negedge clk);
    cke = 1'b0;
    drive(1'b1, NOP, 2'd0, 1'b0, 3'd0);
    @(posedge clk); #1;
    check("R1", 1'b0, 4'd0);
    @(negedge clk);
    cke = 1'b1;
    drive(1'b0, RD, 2'd0, 1'b0, 3'd0);
    @(posedge clk); #1;
    check("R1", 1'b0, 4'd0);
    step(1'b0, RD, 2'd0, 1'b0, 3'd0);
    check("R4", 1'b1, 4'd8);

    // R13: reset clears a pending flag immediately
    rst_n = 1'b0;
    #1;
    check("R13", 1'b0, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b1, NOP, 2'd0, 1'b0, 3'd0);

    // R12: mode register set with an open bank
    step(1'b0, ACT, 2'd1, 1'b0, 3'd0);
    check("R7", 1'b0, 4'd0);
    step(1'b1, NOP, 2'd0, 1'b0, 3'd0);
    step(1'b0, MR, 2'd0, 1'b0, 3'd0);
    check("R12", 1'b1, 4'd9);
    step(1'b1, NOP, 2'd0, 1'b0, 3'd0);
    check("R2", 1'b0, 4'd0);

    report();
    $finish;
  end

endmodule